// File: doc/BRIEF.md
# Spline-Edge Node Evaluator

This block computes one output node of a Kolmogorov–Arnold-style layer. Each input edge has its own learned univariate function. The function is held as a small table of signed samples on a uniform grid over the unsigned input range. The block evaluates each edge by linear interpolation between the two samples that bracket the input. It then adds all edge results in a pipelined adder tree to form the node value.

All edge inputs arrive together as one packed vector, qualified by a valid bit. The tables are constants built into logic, so no memory macro is used. The interpolation multiply is built from shifts and adds over the few fraction bits, so no hard multiplier is used. The pipeline accepts a new vector on every cycle and returns the node sum a fixed number of cycles later, together with a matching valid bit.

With the default parameters there are 4 edges, 8-bit inputs, 16 segments, 8-bit signed samples and a 10-bit signed output.

Top module: `kan_node_eval`

## Requirements
- R1: While `rst` is high, and for the first 4 cycles after it falls, `out_valid` stays low.
- R2: For edge e, the input is bits [8e+7:8e] of `in_vec`, read as unsigned. Its upper 4 bits give the segment k (0..15) and its lower 4 bits give the fraction f (0..15).
- R3: The sample k of edge e (k = 0..15) is the low 8 bits of k·k·(e+1) + k·(2e+3) + 40·e, read as a two's-complement value.
- R4: When f = 0, the edge value equals sample k of that edge exactly.
- R5: When k < 15, the edge value is y0 + floor((y1 − y0)·f / 16), where y0 is sample k and y1 is sample k+1.
- R6: When k = 15, the right-hand sample is sample 15 itself, so the edge value equals sample 15 for every f and the table address never wraps.
- R7: `out_data` is the two's-complement sum of all edge values.
- R8: `out_valid` equals `in_valid` as sampled 4 rising edges earlier. `out_data` belongs to that same sampled vector.
- R9: A new vector is accepted on every cycle. Back-to-back vectors give independent results, and a vector held steady gives a steady output.
- R10: A cycle with `in_valid` low produces `out_valid` low 4 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_vec` |
| in_vec | input | 32 | Four 8-bit unsigned edge inputs, edge 0 in the low byte |
| out_valid | output | 1 | Qualifies `out_data` |
| out_data | output | 10 | Signed node sum |

## Verification
Within a single vector, one edge can sit in the top segment, where the right-hand sample is clamped, while another edge sits exactly on a grid point and others lie mid-segment. All of these feed the same adder tree in the same cycle. Directed vectors put such mixes side by side in one word, and random vectors produce them often. Each vector is judged by summing a per-edge reference interpolation whose clamp and floor rules are taken from the requirements. The random stream also interleaves idle cycles between back-to-back valid vectors, so valid tracking and data are judged together for every cycle.

// File: rtl/kan_node_eval.sv
module kan_node_eval #(
  parameter int N_EDGE   = 4,
  parameter int IN_W     = 8,
  parameter int SEG_BITS = 4,
  parameter int SAMP_W   = 8,
  parameter int LVL      = $clog2(N_EDGE),
  parameter int OUT_W    = SAMP_W + LVL
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [N_EDGE*IN_W-1:0]  in_vec,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int FRAC_W = IN_W - SEG_BITS;
  localparam int PW     = SAMP_W + FRAC_W + 2;
  localparam int LAT    = 2 + LVL;
  localparam logic [SEG_BITS-1:0] TOP = '1;

  function automatic logic signed [SAMP_W-1:0] samp(input int e, input int k);
    int v;
    v = k * k * (e + 1) + k * (2 * e + 3) + 40 * e;
    return SAMP_W'(v);
  endfunction

  logic signed [OUT_W-1:0] node [1:2*N_EDGE-1];
  logic [LAT-1:0] vp;

  always_ff @(posedge clk) begin
    if (rst) vp <= '0;
    else     vp <= {vp[LAT-2:0], in_valid};
  end

  for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
    wire [SEG_BITS-1:0] seg = in_vec[e*IN_W+FRAC_W +: SEG_BITS];
    wire [FRAC_W-1:0]   frc = in_vec[e*IN_W +: FRAC_W];
    wire [SEG_BITS-1:0] nxt = (seg == TOP) ? seg : seg + 1'b1;

    logic signed [SAMP_W-1:0] y0, y1;
    logic [FRAC_W-1:0]        fr;
    logic signed [PW-1:0]     dif, acc, ev;

    always_ff @(posedge clk) begin
      y0 <= samp(e, int'(seg));
      y1 <= samp(e, int'(nxt));
      fr <= frc;
    end

    always_comb begin
      dif = PW'(y1) - PW'(y0);
      acc = '0;
      for (int b = 0; b < FRAC_W; b++)
        if (fr[b]) acc = acc + (dif <<< b);
      ev = PW'(y0) + (acc >>> FRAC_W);
    end

    always_ff @(posedge clk) node[N_EDGE+e] <= OUT_W'(ev);
  end

  for (genvar i = 1; i < N_EDGE; i++) begin : g_tree
    always_ff @(posedge clk) node[i] <= node[2*i] + node[2*i+1];
  end

  assign out_valid = vp[LAT-1];
  assign out_data  = node[1];
endmodule

// File: rtl/kan_node_eval_chk.sv
module kan_node_eval_chk #(
  parameter int N_EDGE = 4,
  parameter int IN_W   = 8,
  parameter int OUT_W  = 10,
  parameter int LAT    = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [N_EDGE*IN_W-1:0]  in_vec,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);
  logic [LAT-1:0]        vsr;
  logic [7:0]            since, runlen;
  logic [N_EDGE*IN_W-1:0] prev_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsr <= '0; since <= '0; runlen <= '0; prev_vec <= '0;
    end else begin
      vsr <= {vsr[LAT-2:0], in_valid};
      if (since != 8'hFF) since <= since + 8'd1;
      prev_vec <= in_vec;
      if (!in_valid) runlen <= '0;
      else if (runlen != 8'd0 && in_vec == prev_vec) begin
        if (runlen != 8'hFF) runlen <= runlen + 8'd1;
      end else runlen <= 8'd1;
    end
  end

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsr[LAT-1]);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    (since < 8'(LAT)) |-> !out_valid);
  assert_steady_output_R9: assert property (@(posedge clk) disable iff (rst)
    (runlen > 8'(LAT) && out_valid) |-> out_data == $past(out_data));
  assert_known_output_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_data));
endmodule

bind kan_node_eval kan_node_eval_chk #(
  .N_EDGE(N_EDGE), .IN_W(IN_W), .OUT_W(OUT_W), .LAT(2 + LVL)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_kan_node_eval.sv
module test_kan_node_eval;
  localparam int CLK_P = 10;
  localparam int LAT   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_vec = '0;
  logic out_valid;
  logic signed [9:0] out_data;

  int checks = 0, errors = 0;
  logic signed [9:0] exp_q [8];
  bit   vld_q [8];
  string tag_q [8];
  int wr = 0;

  always #(CLK_P/2) clk = ~clk;

  kan_node_eval i_kan_node_eval (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R3 table
  function automatic int tab(int e, int k);
    logic [31:0] v;
    v = k * k * (e + 1) + k * (2 * e + 3) + 40 * e;
    return int'($signed(v[7:0]));
  endfunction

  // R2 split, R4/R5/R6 interpolation
  function automatic int edge_val(int e, logic [7:0] x);
    int k, f, y0, y1, d;
    k = int'(x[7:4]); f = int'(x[3:0]);
    y0 = tab(e, k);
    y1 = (k == 15) ? y0 : tab(e, k + 1);
    d = (y1 - y0) * f;
    return y0 + (d >>> 4);
  endfunction

  function automatic int node_ref(logic [31:0] v);
    int s = 0;
    for (int e = 0; e < 4; e++) s += edge_val(e, v[8*e +: 8]);
    return s;
  endfunction

  function automatic string tag_of(logic [31:0] v);
    bit top = 0, grid = 1;
    for (int e = 0; e < 4; e++) begin
      if (v[8*e+4 +: 4] == 4'hF) top = 1;
      if (v[8*e +: 4] != 4'h0) grid = 0;
    end
    if (top)  return "R6/R7";
    if (grid) return "R4/R7";
    return "R5/R7";
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(logic [31:0] v, bit vl);
    int slot;
    @(negedge clk);
    slot = (wr - LAT) & 7;
    chk(out_valid == vld_q[slot], vld_q[slot] ? "R8" : "R10",
        int'(out_valid), int'(vld_q[slot]));
    if (vld_q[slot])
      chk(out_data == exp_q[slot], tag_q[slot], int'(out_data), int'(exp_q[slot]));
    in_vec = v; in_valid = vl;
    exp_q[wr & 7] = 10'(node_ref(v));
    vld_q[wr & 7] = vl;
    tag_q[wr & 7] = tag_of(v);
    wr++;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin vld_q[i] = 0; exp_q[i] = '0; tag_q[i] = ""; end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    end
    @(negedge clk); rst = 1'b0;
    // R1: first LAT steps expect out_valid low (ring starts empty)
    step(32'h0000_0000, 1);
    step(32'h1030_70F0, 1);                 // R4 grid points incl. top grid
    step(32'hFFFF_FFFF, 1);                 // R6 top segment, max fraction
    step(32'h0808_0808, 1);                 // R5 mid-segment
    step(32'hF730_5A00, 1);                 // mix: top, grid, mid
    step(32'h8F9E_A1B7, 0);                 // R10 idle cycle
    step(32'hE1D2_C3B4, 1);                 // R9 back-to-back
    step(32'h0F1F_2F3F, 1);
    for (int i = 0; i < 8; i++) step(32'h6C5B_4A39, 1);   // R9 steady input
    for (int i = 0; i < 600; i++) begin
      logic [31:0] v;
      v = $urandom;
      if (($urandom % 8) == 0) v[8*($urandom % 4) +: 4] = 4'h0;
      if (($urandom % 8) == 0) v[8*($urandom % 4)+4 +: 4] = 4'hF;
      step(v, ($urandom % 5) != 0);
    end
    for (int i = 0; i < LAT + 1; i++) step(32'h0, 0);
    finish_run();
  end
endmodule